// File: doc/BRIEF.md
# Clock Domain Stop Gating Controller

This block sits between the frequency sources and the output pins of a clock generator. It switches off a processor clock domain and a bus clock domain for low-power operation. Each domain has an active-low stop request that may change at any time. The block brings each request into its own clock domain through a flop chain and then runs a small halt/run state machine. It turns the result into a gate enable. That enable is captured on the falling edge of the domain clock and ANDed with the clock. A gated clock therefore always parks low, and every restart begins with a complete high phase.

A configuration word selects which outputs take part in stopping. Each of the bus outputs carries an enable bit and a free-run bit. A free-running output ignores the bus stop request, and a disabled output stays low whatever the request does. The processor output and three auxiliary outputs (reference, fixed 48 MHz, and selectable 24/48 MHz) each have their own enable bit. A global float bit removes the pin drive from every output. After each restart a domain runs for a guaranteed minimum number of pulses before a new stop can act.

Top module: `clk_stop_gate`

## Requirements
- R1: While `rst_n_i` is low every gated clock output is low. After release, each enabled output gives its first high phase at the first rising edge that follows the first falling edge after release.
- R2: `cpu_stop_n_i` is passed through SYNC_STAGES (default 2) flops clocked by `cpu_clk_i`. Let edge k be the first rising edge that samples it low. The processor output still pulses at edges k+1 and k+2, and it is held low through the whole period from edge k+3 on (off latency under 4 cycles).
- R3: Let edge k be the first rising edge that samples `cpu_stop_n_i` high again. The processor output stays low at k+2 and gives a full high phase from edge k+3 on.
- R4: After a processor restart, at least CPU_MIN_ON (default 100) full pulses are delivered before a new stop takes hold. A stop that is already pending holds the output low from the rising edge that follows pulse number CPU_MIN_ON.
- R5: `pci_stop_n_i` acts on `pci_clk_o[j]` with the same latencies as R2 and R3, but only where `pci_run_free_i[j]` is 0. Where that bit is 1, output j keeps running through the stop.
- R6: After a bus restart, at least PCI_MIN_ON (default 10) full pulses are delivered before a new bus stop takes hold.
- R7: When `pci_en_i[j]` is 0, `pci_clk_o[j]` stays low whatever the stop request and the free-run bit say. A change made during a high phase takes effect from the next rising edge.
- R8: When `cpu_en_i`, `ref_en_i`, `f48_en_i` or `fsel_en_i` is 0, the matching output stays low from the next rising edge of its own clock. Setting the bit to 1 restarts the output with a full high phase.
- R9: `drive_en_o` is the inverse of `float_all_i` and follows it in the same cycle. Setting the float bit does not stop any gated clock.
- R10: A stop in one domain leaves the other domain's outputs and the auxiliary outputs toggling without a missed pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n_i | input | 1 | Asynchronous active-low reset |
| cpu_clk_i | input | 1 | Processor domain source clock |
| pci_clk_i | input | 1 | Bus domain source clock |
| ref_clk_i | input | 1 | Reference source clock |
| f48_clk_i | input | 1 | Fixed 48 MHz source clock |
| fsel_clk_i | input | 1 | Selectable 24/48 MHz source clock |
| cpu_stop_n_i | input | 1 | Asynchronous active-low processor stop request |
| pci_stop_n_i | input | 1 | Asynchronous active-low bus stop request |
| pci_run_free_i | input | PCI_OUTS | Per bus output: 1 = ignore bus stop |
| pci_en_i | input | PCI_OUTS | Per bus output: 1 = enabled |
| cpu_en_i | input | 1 | Processor output enable |
| ref_en_i | input | 1 | Reference output enable |
| f48_en_i | input | 1 | 48 MHz output enable |
| fsel_en_i | input | 1 | 24/48 MHz output enable |
| float_all_i | input | 1 | 1 = release the drive of every output |
| cpu_clk_o | output | 1 | Gated processor clock |
| pci_clk_o | output | PCI_OUTS | Gated bus clocks |
| ref_clk_o | output | 1 | Gated reference clock |
| f48_clk_o | output | 1 | Gated 48 MHz clock |
| fsel_clk_o | output | 1 | Gated 24/48 MHz clock |
| drive_en_o | output | 1 | Pad drive enable for all outputs |

## Verification
The outputs are compared in the middle of each high phase, 2 ns after the rising edge, where a running output reads 1 and a gated one reads 0. Stimulus changes 1 ns after a rising edge. A stop or release sampled at edge k therefore affects the output at edge k+3, three rising edges later. Enable and free-run bits act at the very next edge, and the float bit acts in the same cycle. The driver works out each of these cycle numbers from the requirements and queues the expected output word under that number. The monitor compares only when its cycle count reaches the queued number. The minimum-run windows are checked just as exactly, one pulse before and one pulse after the window's last pulse.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

   localparam int unsigned PCI_OUTS_DEF   = 7;
   localparam int unsigned SYNC_DEF       = 2;
   localparam int unsigned CPU_MIN_ON_DEF = 100;
   localparam int unsigned PCI_MIN_ON_DEF = 10;
   localparam int unsigned CPU_MAX_LAT_DEF = 4;

   typedef enum logic {
      DOM_RUN  = 1'b0,
      DOM_HALT = 1'b1
   } dom_state_e;

   // width of a down-counter that must hold n-1
   function automatic int unsigned hold_bits(int unsigned n);
      return (n < 3) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic d_i,
   output logic q_o
);

   logic [STAGES-1:0] chain_q;

   initial begin
      assert (STAGES >= 2) else $error("clkstop_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) chain_q <= '0;
      else          chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/clkstop_dom_fsm.sv
module clkstop_dom_fsm
   import clkstop_pkg::*;
#(
   parameter int unsigned MIN_ON = 10
) (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic stop_req_i,
   output logic halted_o
);

   localparam int unsigned HW = hold_bits(MIN_ON);
   localparam logic [HW-1:0] HOLD_LOAD = HW'(MIN_ON - 1);

   dom_state_e    state_q;
   logic [HW-1:0] hold_q;

   initial begin
      assert (MIN_ON >= 1) else $error("clkstop_dom_fsm: MIN_ON must be at least 1");
   end

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         state_q <= DOM_RUN;
         hold_q  <= '0;
      end else begin
         unique case (state_q)
            DOM_RUN: begin
               if (stop_req_i && (hold_q == '0)) state_q <= DOM_HALT;
               else if (hold_q != '0)            hold_q  <= hold_q - 1'b1;
            end
            DOM_HALT: begin
               if (!stop_req_i) begin
                  state_q <= DOM_RUN;
                  hold_q  <= HOLD_LOAD;
               end
            end
            default: state_q <= DOM_RUN;
         endcase
      end
   end

   assign halted_o = (state_q == DOM_HALT);

endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic en_i,
   output logic clk_o
);

   logic en_q;

   // capture while the clock is low-going so the AND cannot chop a high phase
   always_ff @(negedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) en_q <= 1'b0;
      else          en_q <= en_i;
   end

   assign clk_o = clk_i & en_q;

endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate
   import clkstop_pkg::*;
#(
   parameter int unsigned PCI_OUTS    = PCI_OUTS_DEF,
   parameter int unsigned SYNC_STAGES = SYNC_DEF,
   parameter int unsigned CPU_MIN_ON  = CPU_MIN_ON_DEF,
   parameter int unsigned PCI_MIN_ON  = PCI_MIN_ON_DEF,
   parameter int unsigned CPU_MAX_LAT = CPU_MAX_LAT_DEF
) (
   input  logic                rst_n_i,
   input  logic                cpu_clk_i,
   input  logic                pci_clk_i,
   input  logic                ref_clk_i,
   input  logic                f48_clk_i,
   input  logic                fsel_clk_i,
   input  logic                cpu_stop_n_i,
   input  logic                pci_stop_n_i,
   input  logic [PCI_OUTS-1:0] pci_run_free_i,
   input  logic [PCI_OUTS-1:0] pci_en_i,
   input  logic                cpu_en_i,
   input  logic                ref_en_i,
   input  logic                f48_en_i,
   input  logic                fsel_en_i,
   input  logic                float_all_i,
   output logic                cpu_clk_o,
   output logic [PCI_OUTS-1:0] pci_clk_o,
   output logic                ref_clk_o,
   output logic                f48_clk_o,
   output logic                fsel_clk_o,
   output logic                drive_en_o
);

   // cycles from the first sampling edge to the first suppressed pulse
   localparam int unsigned OFF_LAT  = SYNC_STAGES + 1;
   localparam int unsigned AUX_OUTS = 3;

   initial begin
      assert (OFF_LAT < CPU_MAX_LAT)
         else $error("clk_stop_gate: SYNC_STAGES too deep for the processor latency limit");
      assert (PCI_OUTS >= 1 && PCI_OUTS <= 32)
         else $error("clk_stop_gate: PCI_OUTS out of range");
      assert (CPU_MIN_ON >= 1 && PCI_MIN_ON >= 1)
         else $error("clk_stop_gate: minimum run lengths must be nonzero");
   end

   logic cpu_req, pci_req;
   logic cpu_halted, pci_halted;

   // ---------------- processor domain ----------------
   clkstop_sync #(.STAGES(SYNC_STAGES)) cpu_sync_i (
      .clk_i   (cpu_clk_i),
      .rst_n_i (rst_n_i),
      .d_i     (~cpu_stop_n_i),
      .q_o     (cpu_req)
   );

   clkstop_dom_fsm #(.MIN_ON(CPU_MIN_ON)) cpu_fsm_i (
      .clk_i      (cpu_clk_i),
      .rst_n_i    (rst_n_i),
      .stop_req_i (cpu_req),
      .halted_o   (cpu_halted)
   );

   logic cpu_gate_en;
   assign cpu_gate_en = cpu_en_i & ~cpu_halted;

   clkstop_gate cpu_gate_i (
      .clk_i   (cpu_clk_i),
      .rst_n_i (rst_n_i),
      .en_i    (cpu_gate_en),
      .clk_o   (cpu_clk_o)
   );

   // ---------------- bus domain ----------------
   clkstop_sync #(.STAGES(SYNC_STAGES)) pci_sync_i (
      .clk_i   (pci_clk_i),
      .rst_n_i (rst_n_i),
      .d_i     (~pci_stop_n_i),
      .q_o     (pci_req)
   );

   clkstop_dom_fsm #(.MIN_ON(PCI_MIN_ON)) pci_fsm_i (
      .clk_i      (pci_clk_i),
      .rst_n_i    (rst_n_i),
      .stop_req_i (pci_req),
      .halted_o   (pci_halted)
   );

   logic [PCI_OUTS-1:0] pci_gate_en;
   assign pci_gate_en = pci_en_i & (pci_run_free_i | {PCI_OUTS{~pci_halted}});

   for (genvar j = 0; j < PCI_OUTS; j++) begin : g_pci
      clkstop_gate pci_gate_i (
         .clk_i   (pci_clk_i),
         .rst_n_i (rst_n_i),
         .en_i    (pci_gate_en[j]),
         .clk_o   (pci_clk_o[j])
      );
   end

   // ---------------- auxiliary outputs: enable only ----------------
   logic [AUX_OUTS-1:0] aux_src, aux_en, aux_out;
   assign aux_src = {ref_clk_i, f48_clk_i, fsel_clk_i};
   assign aux_en  = {ref_en_i,  f48_en_i,  fsel_en_i};

   for (genvar a = 0; a < AUX_OUTS; a++) begin : g_aux
      clkstop_gate aux_gate_i (
         .clk_i   (aux_src[a]),
         .rst_n_i (rst_n_i),
         .en_i    (aux_en[a]),
         .clk_o   (aux_out[a])
      );
   end

   assign {ref_clk_o, f48_clk_o, fsel_clk_o} = aux_out;

   assign drive_en_o = ~float_all_i;

endmodule

// File: rtl/clk_stop_gate_chk.sv
module clk_stop_gate_chk #(
   parameter int unsigned PCI_OUTS   = 7,
   parameter int unsigned CPU_MIN_ON = 100,
   parameter int unsigned PCI_MIN_ON = 10
) (
   input logic                rst_n_i,
   input logic                cpu_clk_i,
   input logic                pci_clk_i,
   input logic                ref_clk_i,
   input logic                cpu_stop_n_i,
   input logic                pci_stop_n_i,
   input logic [PCI_OUTS-1:0] pci_run_free_i,
   input logic [PCI_OUTS-1:0] pci_en_i,
   input logic                cpu_en_i,
   input logic                ref_en_i,
   input logic                cpu_clk_o,
   input logic [PCI_OUTS-1:0] pci_clk_o,
   input logic                ref_clk_o,
   input logic                cpu_halted,
   input logic                pci_halted
);

   logic [1:0]  cpu_age, pci_age;
   logic        cpu_seen, pci_seen;
   logic        cpu_neg_ok, pci_neg_ok;
   int unsigned cpu_run_len, pci_run_len;

   always_ff @(posedge cpu_clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         cpu_age     <= '0;
         cpu_seen    <= 1'b0;
         cpu_run_len <= 0;
      end else begin
         if (cpu_age != 2'd3) cpu_age <= cpu_age + 2'd1;
         if (cpu_halted) cpu_seen <= 1'b1;
         if (cpu_halted) cpu_run_len <= 0;
         else if (cpu_run_len < CPU_MIN_ON) cpu_run_len <= cpu_run_len + 1;
      end
   end

   always_ff @(posedge pci_clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         pci_age     <= '0;
         pci_seen    <= 1'b0;
         pci_run_len <= 0;
      end else begin
         if (pci_age != 2'd3) pci_age <= pci_age + 2'd1;
         if (pci_halted) pci_seen <= 1'b1;
         if (pci_halted) pci_run_len <= 0;
         else if (pci_run_len < PCI_MIN_ON) pci_run_len <= pci_run_len + 1;
      end
   end

   always_ff @(negedge cpu_clk_i or negedge rst_n_i) begin
      if (!rst_n_i) cpu_neg_ok <= 1'b0;
      else          cpu_neg_ok <= 1'b1;
   end

   always_ff @(negedge pci_clk_i or negedge rst_n_i) begin
      if (!rst_n_i) pci_neg_ok <= 1'b0;
      else          pci_neg_ok <= 1'b1;
   end

   // R2
   cpu_halt_low_chk: assert property (@(negedge cpu_clk_i) disable iff (!rst_n_i)
      $past(cpu_halted) |-> !cpu_clk_o)
      else $error("processor clock pulsed while halted");

   // R3
   cpu_restart_lat_chk: assert property (@(posedge cpu_clk_i) disable iff (!rst_n_i)
      (cpu_age == 2'd3 && $past(cpu_stop_n_i, 1) && $past(cpu_stop_n_i, 2) && $past(cpu_stop_n_i, 3))
      |-> !cpu_halted)
      else $error("processor domain still halted three edges after release");

   // R3
   cpu_run_pulse_chk: assert property (@(negedge cpu_clk_i) disable iff (!rst_n_i)
      (cpu_neg_ok && !$past(cpu_halted) && $past(cpu_en_i)) |-> cpu_clk_o)
      else $error("processor clock missing while running");

   // R4
   cpu_min_on_chk: assert property (@(posedge cpu_clk_i) disable iff (!rst_n_i)
      ($rose(cpu_halted) && cpu_seen) |-> (cpu_run_len >= CPU_MIN_ON))
      else $error("processor domain halted before its minimum run");

   // R5
   pci_restart_lat_chk: assert property (@(posedge pci_clk_i) disable iff (!rst_n_i)
      (pci_age == 2'd3 && $past(pci_stop_n_i, 1) && $past(pci_stop_n_i, 2) && $past(pci_stop_n_i, 3))
      |-> !pci_halted)
      else $error("bus domain still halted three edges after release");

   // R6
   pci_min_on_chk: assert property (@(posedge pci_clk_i) disable iff (!rst_n_i)
      ($rose(pci_halted) && pci_seen) |-> (pci_run_len >= PCI_MIN_ON))
      else $error("bus domain halted before its minimum run");

   for (genvar j = 0; j < PCI_OUTS; j++) begin : g_pci_chk
      // R5
      pci_free_run_chk: assert property (@(negedge pci_clk_i) disable iff (!rst_n_i)
         (pci_neg_ok && $past(pci_run_free_i[j] && pci_en_i[j])) |-> pci_clk_o[j])
         else $error("free-running bus output was gated");

      // R7
      pci_disabled_chk: assert property (@(negedge pci_clk_i) disable iff (!rst_n_i)
         $past(!pci_en_i[j]) |-> !pci_clk_o[j])
         else $error("disabled bus output pulsed");
   end

   // R8
   ref_disabled_chk: assert property (@(negedge ref_clk_i) disable iff (!rst_n_i)
      $past(!ref_en_i) |-> !ref_clk_o)
      else $error("disabled reference output pulsed");

endmodule

bind clk_stop_gate clk_stop_gate_chk #(
   .PCI_OUTS   (PCI_OUTS),
   .CPU_MIN_ON (CPU_MIN_ON),
   .PCI_MIN_ON (PCI_MIN_ON)
) chk_i (
   .rst_n_i        (rst_n_i),
   .cpu_clk_i      (cpu_clk_i),
   .pci_clk_i      (pci_clk_i),
   .ref_clk_i      (ref_clk_i),
   .cpu_stop_n_i   (cpu_stop_n_i),
   .pci_stop_n_i   (pci_stop_n_i),
   .pci_run_free_i (pci_run_free_i),
   .pci_en_i       (pci_en_i),
   .cpu_en_i       (cpu_en_i),
   .ref_en_i       (ref_en_i),
   .cpu_clk_o      (cpu_clk_o),
   .pci_clk_o      (pci_clk_o),
   .ref_clk_o      (ref_clk_o),
   .cpu_halted     (cpu_halted),
   .pci_halted     (pci_halted)
);

// File: tb/clk_stop_gate_tb_top.sv
module clk_stop_gate_tb_top;

   localparam int NP = 7;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          cpu_stop_n, pci_stop_n;
   logic [NP-1:0] pci_free, pci_en;
   logic          cpu_en, ref_en, f48_en, fsel_en, float_all;
   logic          cpu_o, ref_o, f48_o, fsel_o, drv_o;
   logic [NP-1:0] pci_o;

   always #4 clk = ~clk;   // 125 MHz

   clk_stop_gate dut_i (
      .rst_n_i        (rst_n),
      .cpu_clk_i      (clk),
      .pci_clk_i      (clk),
      .ref_clk_i      (clk),
      .f48_clk_i      (clk),
      .fsel_clk_i     (clk),
      .cpu_stop_n_i   (cpu_stop_n),
      .pci_stop_n_i   (pci_stop_n),
      .pci_run_free_i (pci_free),
      .pci_en_i       (pci_en),
      .cpu_en_i       (cpu_en),
      .ref_en_i       (ref_en),
      .f48_en_i       (f48_en),
      .fsel_en_i      (fsel_en),
      .float_all_i    (float_all),
      .cpu_clk_o      (cpu_o),
      .pci_clk_o      (pci_o),
      .ref_clk_o      (ref_o),
      .f48_clk_o      (f48_o),
      .fsel_clk_o     (fsel_o),
      .drive_en_o     (drv_o)
   );

   typedef struct {
      int          cyc;
      logic [10:0] v;     // {cpu, pci[6:0], ref, f48, fsel}
      logic        drv;
      string       tag;
   } exp_t;

   exp_t sb_q[$];
   int   cyc    = 0;
   int   checks = 0;
   int   errors = 0;
   bit   done   = 0;

   // ---------------- monitor: sample mid high phase ----------------
   initial begin
      forever begin
         @(posedge clk);
         cyc = cyc + 1;
         #2;
         while (sb_q.size() > 0 && sb_q[0].cyc <= cyc) begin
            exp_t e;
            logic [10:0] act;
            e = sb_q.pop_front();
            act = {cpu_o, pci_o, ref_o, f48_o, fsel_o};
            checks++;
            if (e.cyc < cyc) begin
               errors++;
               $display("FAIL %s: got missed-sample at cycle %0d expected cycle %0d", e.tag, cyc, e.cyc);
            end else if (act !== e.v || drv_o !== e.drv) begin
               errors++;
               $display("FAIL %s: cycle %0d got out=%b drv=%b expected out=%b drv=%b",
                        e.tag, cyc, act, drv_o, e.v, e.drv);
            end
         end
      end
   end

   // ---------------- driver helpers ----------------
   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   function automatic logic [10:0] expv(input bit cpu_run, input bit pci_run);
      return {cpu_en & cpu_run,
              pci_en & (pci_free | {NP{pci_run}}),
              ref_en, f48_en, fsel_en};
   endfunction

   task automatic push_raw(input int at, input logic [10:0] v, input logic drv, input string tag);
      exp_t e;
      e.cyc = at; e.v = v; e.drv = drv; e.tag = tag;
      sb_q.push_back(e);
   endtask

   task automatic push(input int ofs, input bit cpu_run, input bit pci_run, input string tag);
      push_raw(cyc + ofs, expv(cpu_run, pci_run), ~float_all, tag);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      rst_n = 1'b0; cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
      pci_free = '0; pci_en = '1;
      cpu_en = 1'b1; ref_en = 1'b1; f48_en = 1'b1; fsel_en = 1'b1;
      float_all = 1'b0;

      // R1: outputs low in reset, running one edge after release
      push_raw(3, 11'b0, 1'b1, "R1 reset low");
      step(5);
      rst_n = 1'b1;
      push(1, 1, 1, "R1 first pulse after release");
      push(3, 1, 1, "R1 running");
      step(4);

      // R2 / R10: processor stop, bus keeps running
      cpu_stop_n = 1'b0;
      push(3, 1, 1, "R2 still pulsing at k+2");
      push(4, 0, 1, "R2 held low from k+3");
      push(10, 0, 1, "R10 bus and aux undisturbed");
      step(12);

      // R3: processor restart
      cpu_stop_n = 1'b1;
      push(3, 0, 1, "R3 still low at k+2");
      push(4, 1, 1, "R3 full pulse at k+3");
      step(4);
      // R4: new stop during minimum run
      cpu_stop_n = 1'b0;
      push(99, 1, 1, "R4 last guaranteed pulse");
      push(100, 0, 1, "R4 stop after minimum run");
      step(106);
      cpu_stop_n = 1'b1;
      push(4, 1, 1, "R3 restart after long stop");
      step(110);

      // R5: bus stop with free-run on outputs 0 and 2
      pci_free = 7'b0000101;
      pci_stop_n = 1'b0;
      push(1, 1, 1, "R5 free-run bits idle while running");
      push(3, 1, 1, "R5 still pulsing at k+2");
      push(4, 1, 0, "R5 only free-run outputs pulse");
      push(8, 1, 0, "R10 processor undisturbed by bus stop");
      step(10);
      pci_stop_n = 1'b1;
      push(3, 1, 0, "R5 still low at k+2");
      push(4, 1, 1, "R5 restart at k+3");
      step(4);
      // R6: bus minimum run
      pci_stop_n = 1'b0;
      push(9, 1, 1, "R6 last guaranteed bus pulse");
      push(10, 1, 0, "R6 stop after minimum run");
      step(12);
      pci_stop_n = 1'b1;
      push(4, 1, 1, "R5 restart");
      step(15);

      // R7: per-output enables on the bus outputs
      pci_en = 7'b1110110;
      push(1, 1, 1, "R7 disabled bus outputs low");
      step(2);
      pci_stop_n = 1'b0;
      push(4, 1, 0, "R7 disable beats free-run during stop");
      step(6);
      pci_stop_n = 1'b1;
      push(4, 1, 1, "R7 restart with disables");
      step(15);
      pci_en = '1; pci_free = '0;
      step(2);

      // R8: processor and auxiliary enables
      cpu_en = 1'b0; ref_en = 1'b0;
      push(1, 1, 1, "R8 processor and reference disabled");
      step(3);
      f48_en = 1'b0; fsel_en = 1'b0;
      push(1, 1, 1, "R8 48 and 24/48 disabled");
      step(3);
      cpu_en = 1'b1; ref_en = 1'b1; f48_en = 1'b1; fsel_en = 1'b1;
      push(1, 1, 1, "R8 re-enabled");
      step(3);

      // R9: global float
      float_all = 1'b1;
      push(1, 1, 1, "R9 float releases drive, clocks run");
      step(3);
      float_all = 1'b0;
      push(1, 1, 1, "R9 drive restored");
      step(3);

      while (sb_q.size() > 0) step(1);
      step(2);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule